// File: doc/BRIEF.md
# SPI Receive Holding Buffer with Selectable Overwrite

This block sits between the receive shift register of an SPI peripheral and the software-visible receive register. Each time the shifter finishes a byte it raises a one-cycle strobe with the byte on a data bus. The block then decides whether the byte goes into the holding buffer. It keeps a full flag, which means unread data is waiting, and a sticky overflow flag, which means a byte arrived while earlier data was still unread.

A mode input selects what happens to a byte that arrives while the buffer is full. With the mode off, the buffer keeps the old byte and the new one is lost. With the mode on, the newest byte always replaces the buffer contents. This suits daisy-chained SPI, where software only needs the last byte of a burst. In both modes such an arrival raises the overflow flag. Software reads the buffer with a read strobe and clears the overflow flag with a separate clear strobe. All outputs are registered and change on the clock edge that samples the strobe.

Top module: `spi_rx_hold`

## Requirements
- R1: A byte strobe whose byte is stored sets the full flag at the next edge. With the mode off, a byte is stored only when the buffer is empty or a read is in the same cycle. With the mode on, every byte is stored.
- R2: With the mode off (overwriteEn=0), a byte strobe while full and with no read in the same cycle leaves the buffer contents unchanged.
- R3: With the mode on (overwriteEn=1), every byte strobe writes its byte into the buffer, whether or not the buffer is full.
- R4: In either mode, a byte strobe while full and with no read in the same cycle sets the overflow flag.
- R5: A read strobe with no byte strobe in the same cycle clears the full flag at the next edge. A read while the buffer is empty changes nothing.
- R6: The overflow flag stays set until a clear strobe. If a clear and a new overflow event fall in the same cycle, the flag stays set.
- R7: A byte strobe and a read strobe in the same cycle store the new byte, keep the full flag set and do not set the overflow flag.
- R8: After reset the buffer holds 0 and the full and overflow flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| byteDone | input | 1 | One-cycle strobe: a received byte is complete |
| byteData | input | DATA_W | Byte delivered with byteDone |
| swRead | input | 1 | One-cycle strobe: software reads the buffer |
| swClrOvf | input | 1 | One-cycle strobe: software clears the overflow flag |
| overwriteEn | input | 1 | 1 = the newest byte always replaces the buffer |
| rxBuf | output | DATA_W | Software-visible receive buffer |
| bufFull | output | 1 | Unread data is held in rxBuf |
| overflow | output | 1 | Sticky flag: a byte arrived while the buffer was full |

## Verification
The assertions check the per-cycle rules on every cycle:
- a stored byte sets the full flag;
- the buffer stays unchanged in the protected mode and takes the byte in overwrite mode;
- the overflow flag is raised and then stays set;
- a read on its own clears the full flag;
- a read in the same cycle as a byte keeps the overflow flag clear.

Only the bench scenarios can show longer behaviour, such as:
- the last byte of a burst surviving in overwrite mode;
- the first byte surviving several lost bytes in protected mode;
- the reset values;
- the ordering when a clear and a new overflow event fall in the same cycle.

// File: rtl/spi_rx_hold_pkg.sv
package spi_rx_hold_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadBuf;   // capture incoming byte into the buffer
  } rxCtrlT;

  // Classification of one cycle's events
  typedef enum logic [1:0] {
    EV_IDLE   = 2'd0,
    EV_STORE  = 2'd1,  // byte arrives into free (or concurrently read) buffer
    EV_COLL   = 2'd2,  // byte arrives while buffer holds unread data
    EV_READ   = 2'd3   // software read with no arrival
  } rxEventT;

endpackage

// File: rtl/spi_rx_hold_ctrl.sv
module spi_rx_hold_ctrl
  import spi_rx_hold_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   byteDone,
  input  logic   swRead,
  input  logic   swClrOvf,
  input  logic   overwriteEn,
  output rxCtrlT ctrl,
  output logic   fullQ,
  output logic   ovfQ
);

  rxEventT evt;
  logic    fullD;
  logic    ovfD;

  // Classify the cycle
  always_comb begin
    if (byteDone && (!fullQ || swRead)) evt = EV_STORE;
    else if (byteDone)                  evt = EV_COLL;
    else if (swRead)                    evt = EV_READ;
    else                                evt = EV_IDLE;
  end

  // Decide buffer load and next flag values
  always_comb begin
    ctrl.loadBuf = 1'b0;
    fullD        = fullQ;
    ovfD         = ovfQ && !swClrOvf;
    unique case (evt)
      EV_STORE: begin
        ctrl.loadBuf = 1'b1;
        fullD        = 1'b1;
      end
      EV_COLL: begin
        ctrl.loadBuf = overwriteEn;
        fullD        = 1'b1;
        ovfD         = 1'b1;   // new event wins over a same-cycle clear
      end
      EV_READ: fullD = 1'b0;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fullQ <= 1'b0;
      ovfQ  <= 1'b0;
    end else begin
      fullQ <= fullD;
      ovfQ  <= ovfD;
    end
  end

endmodule

// File: rtl/spi_rx_hold_dp.sv
module spi_rx_hold_dp
  import spi_rx_hold_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxCtrlT            ctrl,
  input  logic [DATA_W-1:0] byteData,
  output logic [DATA_W-1:0] bufQ
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             bufQ <= '0;
    else if (ctrl.loadBuf) bufQ <= byteData;
  end

endmodule

// File: rtl/spi_rx_hold.sv
module spi_rx_hold
  import spi_rx_hold_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteDone,
  input  logic [DATA_W-1:0] byteData,
  input  logic              swRead,
  input  logic              swClrOvf,
  input  logic              overwriteEn,
  output logic [DATA_W-1:0] rxBuf,
  output logic              bufFull,
  output logic              overflow
);

  rxCtrlT ctrl;

  spi_rx_hold_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .byteDone    (byteDone),
    .swRead      (swRead),
    .swClrOvf    (swClrOvf),
    .overwriteEn (overwriteEn),
    .ctrl        (ctrl),
    .fullQ       (bufFull),
    .ovfQ        (overflow)
  );

  spi_rx_hold_dp #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .byteData (byteData),
    .bufQ     (rxBuf)
  );

endmodule

// File: rtl/spi_rx_hold_chk.sv
module spi_rx_hold_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              byteDone,
  input logic [DATA_W-1:0] byteData,
  input logic              swRead,
  input logic              swClrOvf,
  input logic              overwriteEn,
  input logic [DATA_W-1:0] rxBuf,
  input logic              bufFull,
  input logic              overflow
);

  AST_FULL_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    byteDone |=> bufFull); // R1

  AST_KEEP_OLD_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    (byteDone && bufFull && !swRead && !overwriteEn) |=> $stable(rxBuf)); // R2

  AST_OVERWRITE_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    (byteDone && overwriteEn) |=> (rxBuf == $past(byteData))); // R3

  AST_OVF_RAISED: assert property (@(posedge clk) disable iff (!rstN)
    (byteDone && bufFull && !swRead) |=> overflow); // R4

  AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    (swRead && !byteDone) |=> !bufFull); // R5

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !swClrOvf) |=> overflow); // R6

  AST_NO_OVF_ON_READ: assert property (@(posedge clk) disable iff (!rstN)
    (!overflow && byteDone && swRead) |=> (!overflow && bufFull)); // R7

endmodule

bind spi_rx_hold spi_rx_hold_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .byteDone    (byteDone),
  .byteData    (byteData),
  .swRead      (swRead),
  .swClrOvf    (swClrOvf),
  .overwriteEn (overwriteEn),
  .rxBuf       (rxBuf),
  .bufFull     (bufFull),
  .overflow    (overflow)
);

// File: tb/tb_spi_rx_hold.sv
module tb_spi_rx_hold;

  localparam int DW      = 8;
  localparam int CLK_PER = 10;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          byteDone = 1'b0;
  logic [DW-1:0] byteData = '0;
  logic          swRead = 1'b0;
  logic          swClrOvf = 1'b0;
  logic          overwriteEn = 1'b0;
  logic [DW-1:0] rxBuf;
  logic          bufFull;
  logic          overflow;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  spi_rx_hold #(.DATA_W(DW)) dut (
    .clk(clk), .rstN(rstN), .byteDone(byteDone), .byteData(byteData),
    .swRead(swRead), .swClrOvf(swClrOvf), .overwriteEn(overwriteEn),
    .rxBuf(rxBuf), .bufFull(bufFull), .overflow(overflow)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One cycle of strobes: driven at a falling edge, held over one rising edge.
  // Outputs are sampled at the following falling edge.
  task automatic cyc(bit done, logic [DW-1:0] d, bit rd, bit clr);
    @(negedge clk);
    byteDone = done; byteData = d; swRead = rd; swClrOvf = clr;
    @(negedge clk);
    byteDone = 0; swRead = 0; swClrOvf = 0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0;
    @(negedge clk);
    rstN = 1;
  endtask

  task automatic tReset();
    doReset();
    chk("R8 buf",  rxBuf, 0);
    chk("R8 full", bufFull, 0);
    chk("R8 ovf",  overflow, 0);
  endtask

  task automatic tLoadRead();
    overwriteEn = 0;
    cyc(1, 8'hA5, 0, 0);
    chk("R1 full", bufFull, 1);
    chk("R1 buf",  rxBuf, 8'hA5);
    chk("R1 ovf",  overflow, 0);
    cyc(0, 8'h00, 1, 0);
    chk("R5 full cleared", bufFull, 0);
    chk("R5 buf kept", rxBuf, 8'hA5);
    cyc(0, 8'h00, 1, 0);
    chk("R5 read empty full", bufFull, 0);
    chk("R5 read empty ovf", overflow, 0);
  endtask

  task automatic tProtected();
    doReset();
    overwriteEn = 0;
    cyc(1, 8'h11, 0, 0);
    cyc(1, 8'h22, 0, 0);
    chk("R2 buf kept", rxBuf, 8'h11);
    chk("R4 ovf set", overflow, 1);
    chk("R2 full", bufFull, 1);
    cyc(1, 8'h33, 0, 0);
    chk("R2 buf kept again", rxBuf, 8'h11);
    cyc(0, 8'h00, 1, 0);
    chk("R6 ovf sticky after read", overflow, 1);
    chk("R5 full after read", bufFull, 0);
    cyc(0, 8'h00, 0, 1);
    chk("R6 ovf cleared", overflow, 0);
  endtask

  task automatic tOverwrite();
    doReset();
    overwriteEn = 1;
    cyc(1, 8'h01, 0, 0);
    chk("R3 first", rxBuf, 8'h01);
    chk("R3 no ovf", overflow, 0);
    for (int i = 2; i <= 5; i++) begin
      cyc(1, DW'(i * 8'h11), 0, 0);
      chk("R3 newest", rxBuf, i * 8'h11);
    end
    chk("R4 ovf overwrite mode", overflow, 1);
    chk("R1 full overwrite", bufFull, 1);
    overwriteEn = 0;
  endtask

  task automatic tSimultaneous();
    doReset();
    overwriteEn = 0;
    cyc(1, 8'h5A, 0, 0);
    cyc(1, 8'hC3, 1, 0);
    chk("R7 buf new", rxBuf, 8'hC3);
    chk("R7 full", bufFull, 1);
    chk("R7 no ovf", overflow, 0);
  endtask

  task automatic tClearVsSet();
    doReset();
    overwriteEn = 0;
    cyc(1, 8'h77, 0, 0);
    cyc(1, 8'h88, 0, 0);
    chk("R4 ovf", overflow, 1);
    cyc(1, 8'h99, 0, 1);
    chk("R6 set wins over clear", overflow, 1);
    chk("R2 buf", rxBuf, 8'h77);
    cyc(0, 8'h00, 0, 1);
    chk("R6 clear alone", overflow, 0);
  endtask

  initial begin
    tReset();
    tLoadRead();
    tProtected();
    tOverwrite();
    tSimultaneous();
    tClearVsSet();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PER * 5000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule